// File: doc/BRIEF.md
# Windowed Watchdog Reset Controller

This block supervises a host processor. A period counter advances on a 1 ms tick input. The host must restart the counter by pulsing a clear strobe, which arrives from an SPI register interface that is outside this block. In windowed mode each period starts with a closed half and ends with an open half. A clear in the closed half is a fault. In time-out mode a clear is good at any point in the period. If a period runs out without a good clear, the block also records a fault.

A fault pulls the active-low reset output low for a parameterised number of ticks. After that the counter starts again from the start of the closed window. The active-low watchdog flag falls together with the reset output. The flag stays low after the reset pulse ends, until the host makes a good clear. When the supply-good input is low, reset is held low until supply-good returns. This covers power-up and wake-up as well. The flag comes up from low to high with the first release after power-up.

The mode bit and the period select are sampled only when the counter restarts. A change to either one therefore takes effect with the next period. The counter runs only while the run-enable input reports a normal or standby operating mode.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rst_n` is low, and afterwards while `supply_ok` stays low, `rst_out_n` and `wd_flag_n` are both 0.
- R2: In the cycle after `supply_ok` is first seen high, `rst_out_n` and `wd_flag_n` both rise to 1. The counter starts at zero.
- R3: In windowed mode (captured mode bit 0) a clear while the count is below half the period is a fault. On the next edge `rst_out_n` and `wd_flag_n` go low.
- R4: In windowed mode a clear while the count is at or above half the period is good. It restarts the count at zero and leaves `rst_out_n` high.
- R5: When a period of P ticks passes with no good clear, the P-th tick is a fault. `rst_out_n` then stays low for exactly RST_TICKS ticks (default 1) and is released on the edge of the last of those ticks. The count restarts at zero.
- R6: After a fault, `wd_flag_n` stays 0 through and after the reset pulse. It returns to 1 only on a good clear.
- R7: In time-out mode (captured mode bit 1) a clear is good at any count. Expiry after P ticks still causes a fault.
- R8: Period select codes 0, 1, 2 and 3 give P = 10, 45, 100 and 350 ticks. The code is sampled only at a restart: power-up release, fault release or good clear.
- R9: When `supply_ok` falls during operation, `rst_out_n` is 0 from the next edge until `supply_ok` returns, and `wd_flag_n` keeps its value. On return the count restarts at zero.
- R10: While `run_en` is 0 the count is held at zero, ticks cause no expiry and clears are ignored.
- R11: The mode bit is sampled only at a restart. After `rst_n` the captured mode is windowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| tick_ms | input | 1 | One-cycle pulse per millisecond time base |
| supply_ok | input | 1 | Supply in range (digital comparator result) |
| run_en | input | 1 | High in operating modes where the watchdog runs |
| mode_timeout | input | 1 | 0 windowed, 1 plain time-out |
| period_sel | input | 2 | Period code, 0..3 |
| clear_stb | input | 1 | One-cycle watchdog clear write strobe |
| rst_out_n | output | 1 | Active-low reset to the host |
| wd_flag_n | output | 1 | Active-low watchdog fault flag |

## Verification
A count that is off by one shifts the window edge or the expiry tick by one tick. The test clears at the last closed count and the first open count, and lets each period code run to P-1 and then P ticks, so such an error shows as a wrong `rst_out_n` level within one tick. If a configuration is captured at the wrong time, the old period or mode stays in force for a whole period. A fault flag that is cleared or latched wrongly shows on `wd_flag_n` on the edge after the reset pulse ends, or after the next clear.

// File: rtl/wdr_pkg.sv
// Shared types for the watchdog reset controller.
// Assumes: one controller state register in wdr_reset_ctrl uses this enum.
package wdr_pkg;
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,   // supply out of range or power-up: reset held
        ST_RUN   = 2'd1,   // reset released, watchdog supervising
        ST_FAULT = 2'd2    // watchdog reset pulse in progress
    } wdr_state_t;
endpackage

// File: rtl/wdr_cfg_latch.sv
// Captures mode and period select at each counter restart and decodes
// the period length and window edge in ticks.
// Assumes: capture is high in the cycle in which the counter restarts.
module wdr_cfg_latch #(
    parameter int P0    = 10,
    parameter int P1    = 45,
    parameter int P2    = 100,
    parameter int P3    = 350,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             mode_timeout_in,
    input  logic [1:0]       period_sel_in,
    output logic             windowed,
    output logic [CNT_W-1:0] period_ticks,
    output logic [CNT_W-1:0] half_ticks
);
    logic [1:0] sel_q;
    logic       win_q;

    // Hold the configuration used by the running period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 2'd0;
            win_q <= 1'b1;
        end else if (capture) begin
            sel_q <= period_sel_in;
            win_q <= ~mode_timeout_in;
        end
    end

    // Decode the period length from the captured code.
    always_comb begin
        case (sel_q)
            2'd0:    period_ticks = CNT_W'(P0);
            2'd1:    period_ticks = CNT_W'(P1);
            2'd2:    period_ticks = CNT_W'(P2);
            default: period_ticks = CNT_W'(P3);
        endcase
    end

    assign half_ticks = period_ticks >> 1;
    assign windowed   = win_q;

    // R8
    sel_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_q) |-> $past(capture));
    // R11
    mode_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(win_q) |-> $past(capture));
endmodule

// File: rtl/wdr_window_timer.sv
// Tick counter for one watchdog period, with closed-window and
// last-tick decodes.
// Assumes: restart wins over advance, and advance is never high on the
// last tick (the controller turns that tick into a fault instead).
module wdr_window_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             advance,
    input  logic [CNT_W-1:0] period_ticks,
    input  logic [CNT_W-1:0] half_ticks,
    output logic             in_closed,
    output logic             at_last
);
    logic [CNT_W-1:0] cnt;

    // Count elapsed ticks of the current period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (advance) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign in_closed = cnt < half_ticks;
    assign at_last   = cnt == (period_ticks - CNT_W'(1));

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < period_ticks);
endmodule

// File: rtl/wdr_reset_ctrl.sv
// Supervisor state machine. It holds reset while the supply is bad,
// judges clears against the window, times the reset pulse and keeps the
// fault flag.
// Assumes: clear_stb and tick are one-cycle pulses; RST_TICKS >= 1.
module wdr_reset_ctrl
    import wdr_pkg::*;
#(
    parameter int RST_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic run_en,
    input  logic clear_stb,
    input  logic tick,
    input  logic windowed,
    input  logic in_closed,
    input  logic at_last,
    output logic restart,
    output logic capture,
    output logic advance,
    output logic rst_out_n,
    output logic wd_flag_n
);
    localparam int RST_W = $clog2(RST_TICKS + 1);

    wdr_state_t       state;
    logic [RST_W-1:0] rcnt;
    logic             por_low;
    logic             fault_low;
    logic             running;
    logic             bad_clear;
    logic             good_clear;
    logic             expire;
    logic             release_hold;
    logic             release_fault;

    // Decode the events of this cycle.
    always_comb begin
        running       = (state == ST_RUN) && run_en && supply_ok;
        bad_clear     = running && clear_stb && windowed && in_closed;
        good_clear    = running && clear_stb && !(windowed && in_closed);
        expire        = running && !clear_stb && tick && at_last;
        release_hold  = (state == ST_HOLD) && supply_ok;
        release_fault = (state == ST_FAULT) && supply_ok && tick
                        && (rcnt == RST_W'(RST_TICKS - 1));
    end

    assign capture = good_clear || release_hold || release_fault;
    assign restart = capture || (state != ST_RUN) || !run_en;
    assign advance = running && tick && !clear_stb && !at_last;

    // Controller state transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HOLD;
        end else begin
            case (state)
                ST_HOLD:  if (supply_ok) state <= ST_RUN;
                ST_RUN:   if (!supply_ok) state <= ST_HOLD;
                          else if (bad_clear || expire) state <= ST_FAULT;
                ST_FAULT: if (!supply_ok) state <= ST_HOLD;
                          else if (release_fault) state <= ST_RUN;
                default:  state <= ST_HOLD;
            endcase
        end
    end

    // Count ticks of the reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_FAULT) begin
            rcnt <= '0;
        end else if (tick) begin
            rcnt <= rcnt + RST_W'(1);
        end
    end

    // Power-up part of the flag: low until the first supply release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            por_low <= 1'b1;
        end else if (release_hold) begin
            por_low <= 1'b0;
        end
    end

    // Fault part of the flag: set on a fault, cleared by a good clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_low <= 1'b0;
        end else if (bad_clear || expire) begin
            fault_low <= 1'b1;
        end else if (good_clear) begin
            fault_low <= 1'b0;
        end
    end

    assign rst_out_n = (state == ST_RUN);
    assign wd_flag_n = !(por_low || fault_low);

    // R9
    supply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !rst_out_n);
    // R6
    fault_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT) |-> !wd_flag_n);
    // R6
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_flag_n) |-> ($past(clear_stb) || $past(state == ST_HOLD)));
    // R10
    idle_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !run_en && supply_ok) |=> (state == ST_RUN));
endmodule

// File: rtl/wdog_supervisor.sv
// Top of the windowed watchdog reset controller. It joins the config
// latch, the period timer and the supervisor state machine.
// Assumes: tick_ms is a one-cycle pulse per millisecond in the clk domain.
module wdog_supervisor #(
    parameter int P0        = 10,
    parameter int P1        = 45,
    parameter int P2        = 100,
    parameter int P3        = 350,
    parameter int RST_TICKS = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       supply_ok,
    input  logic       run_en,
    input  logic       mode_timeout,
    input  logic [1:0] period_sel,
    input  logic       clear_stb,
    output logic       rst_out_n,
    output logic       wd_flag_n
);
    localparam int P_01  = (P0 > P1) ? P0 : P1;
    localparam int P_23  = (P2 > P3) ? P2 : P3;
    localparam int P_MAX = (P_01 > P_23) ? P_01 : P_23;
    localparam int CNT_W = $clog2(P_MAX + 1);

    logic             windowed;
    logic [CNT_W-1:0] period_ticks;
    logic [CNT_W-1:0] half_ticks;
    logic             in_closed;
    logic             at_last;
    logic             restart;
    logic             capture;
    logic             advance;

    wdr_cfg_latch #(
        .P0(P0), .P1(P1), .P2(P2), .P3(P3), .CNT_W(CNT_W)
    ) u_cfg (
        .clk            (clk),
        .rst_n          (rst_n),
        .capture        (capture),
        .mode_timeout_in(mode_timeout),
        .period_sel_in  (period_sel),
        .windowed       (windowed),
        .period_ticks   (period_ticks),
        .half_ticks     (half_ticks)
    );

    wdr_window_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .advance     (advance),
        .period_ticks(period_ticks),
        .half_ticks  (half_ticks),
        .in_closed   (in_closed),
        .at_last     (at_last)
    );

    wdr_reset_ctrl #(
        .RST_TICKS(RST_TICKS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .supply_ok(supply_ok),
        .run_en   (run_en),
        .clear_stb(clear_stb),
        .tick     (tick_ms),
        .windowed (windowed),
        .in_closed(in_closed),
        .at_last  (at_last),
        .restart  (restart),
        .capture  (capture),
        .advance  (advance),
        .rst_out_n(rst_out_n),
        .wd_flag_n(wd_flag_n)
    );
endmodule

// File: tb/wdog_supervisor_bench.sv
// Directed bench: one task per scenario; all samples at the falling edge.
module wdog_supervisor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       supply_ok = 1'b0;
    logic       run_en = 1'b1;
    logic       mode_timeout = 1'b0;
    logic [1:0] period_sel = 2'd0;
    logic       clear_stb = 1'b0;
    logic       rst_out_n;
    logic       wd_flag_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    wdog_supervisor u_wdog_supervisor (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_ms     (tick_ms),
        .supply_ok   (supply_ok),
        .run_en      (run_en),
        .mode_timeout(mode_timeout),
        .period_sel  (period_sel),
        .clear_stb   (clear_stb),
        .rst_out_n   (rst_out_n),
        .wd_flag_n   (wd_flag_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Ends a hung run as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG_CYCLES && !done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_ms = 1'b1;
            @(negedge clk);
            tick_ms = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic do_clear();
        clear_stb = 1'b1;
        @(negedge clk);
        clear_stb = 1'b0;
    endtask

    task automatic t_reset_hold();
        repeat (3) @(negedge clk);
        chk("R1 rst during reset", rst_out_n, 1'b0);
        chk("R1 flag during reset", wd_flag_n, 1'b0);
        rst_n = 1'b1;
        do_ticks(3);
        chk("R1 rst while supply low", rst_out_n, 1'b0);
        chk("R1 flag while supply low", wd_flag_n, 1'b0);
    endtask

    task automatic t_power_up();
        supply_ok = 1'b1;
        @(negedge clk);
        chk("R2 rst released", rst_out_n, 1'b1);
        chk("R2 flag high", wd_flag_n, 1'b1);
    endtask

    task automatic t_closed_clear();
        do_ticks(4);
        do_clear();
        chk("R3 rst on closed clear", rst_out_n, 1'b0);
        chk("R3 flag on closed clear", wd_flag_n, 1'b0);
        repeat (3) @(negedge clk);
        chk("R5 pulse waits for tick", rst_out_n, 1'b0);
        do_ticks(1);
        chk("R5 rst released", rst_out_n, 1'b1);
        chk("R6 flag still low", wd_flag_n, 1'b0);
    endtask

    task automatic t_open_clear();
        do_ticks(5);
        do_clear();
        chk("R4 open clear keeps rst", rst_out_n, 1'b1);
        chk("R6 flag cleared", wd_flag_n, 1'b1);
    endtask

    task automatic t_expire();
        do_ticks(9);
        chk("R5 no expiry at P-1", rst_out_n, 1'b1);
        do_ticks(1);
        chk("R5 expiry at P", rst_out_n, 1'b0);
        chk("R6 flag on expiry", wd_flag_n, 1'b0);
        do_ticks(1);
        chk("R5 release", rst_out_n, 1'b1);
        do_ticks(5);
        do_clear();
        chk("R6 flag after clear", wd_flag_n, 1'b1);
    endtask

    task automatic t_period_sel();
        period_sel = 2'd1;
        do_ticks(5);
        do_clear();
        do_ticks(9);
        chk("R8 new period in force", rst_out_n, 1'b1);
        do_ticks(13);
        do_clear();
        chk("R8 open edge at 22", rst_out_n, 1'b1);
        do_ticks(21);
        do_clear();
        chk("R8 closed at 21", rst_out_n, 1'b0);
        do_ticks(1);
        do_ticks(44);
        chk("R8 no expiry at 44", rst_out_n, 1'b1);
        do_ticks(1);
        chk("R8 expiry at 45", rst_out_n, 1'b0);
        do_ticks(1);
        period_sel = 2'd3;
        do_ticks(22);
        do_clear();
        do_ticks(349);
        chk("R8 no expiry at 349", rst_out_n, 1'b1);
        do_ticks(1);
        chk("R8 expiry at 350", rst_out_n, 1'b0);
        do_ticks(1);
        period_sel = 2'd2;
        do_ticks(175);
        do_clear();
        do_ticks(99);
        chk("R8 no expiry at 99", rst_out_n, 1'b1);
        do_ticks(1);
        chk("R8 expiry at 100", rst_out_n, 1'b0);
        do_ticks(1);
        period_sel = 2'd0;
        do_ticks(50);
        do_clear();
        chk("R8 flag after clear", wd_flag_n, 1'b1);
    endtask

    task automatic t_timeout_mode();
        mode_timeout = 1'b1;
        do_ticks(5);
        do_clear();
        do_clear();
        chk("R7 clear at count 0", rst_out_n, 1'b1);
        do_ticks(2);
        do_clear();
        chk("R7 clear at count 2", rst_out_n, 1'b1);
        do_ticks(9);
        chk("R7 no expiry at P-1", rst_out_n, 1'b1);
        do_ticks(1);
        chk("R7 expiry in time-out mode", rst_out_n, 1'b0);
        do_ticks(1);
        mode_timeout = 1'b0;
        do_clear();
        chk("R11 old mode until restart", rst_out_n, 1'b1);
        chk("R11 flag after clear", wd_flag_n, 1'b1);
        do_clear();
        chk("R11 windowed after restart", rst_out_n, 1'b0);
        do_ticks(1);
        do_ticks(5);
        do_clear();
    endtask

    task automatic t_supply_drop();
        do_ticks(3);
        supply_ok = 1'b0;
        @(negedge clk);
        chk("R9 rst on supply loss", rst_out_n, 1'b0);
        chk("R9 flag kept", wd_flag_n, 1'b1);
        do_ticks(20);
        chk("R9 rst held", rst_out_n, 1'b0);
        supply_ok = 1'b1;
        @(negedge clk);
        chk("R9 rst on return", rst_out_n, 1'b1);
        do_ticks(9);
        chk("R9 count restarted", rst_out_n, 1'b1);
        do_ticks(1);
        chk("R9 expiry from zero", rst_out_n, 1'b0);
        do_ticks(1);
        do_ticks(5);
        do_clear();
    endtask

    task automatic t_disabled();
        run_en = 1'b0;
        do_ticks(30);
        chk("R10 no expiry when idle", rst_out_n, 1'b1);
        do_clear();
        chk("R10 clear ignored", rst_out_n, 1'b1);
        chk("R10 flag kept", wd_flag_n, 1'b1);
        run_en = 1'b1;
        @(negedge clk);
        do_clear();
        chk("R10 count held at zero", rst_out_n, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset_hold();
        t_power_up();
        t_closed_clear();
        t_open_clear();
        t_expire();
        t_period_sel();
        t_timeout_mode();
        t_supply_drop();
        t_disabled();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule